// File: doc/BRIEF.md
# Two-Dimensional 8x8 Cosine Transform Engine

This block transforms square tiles of 8 by 8 samples between the pixel domain and the frequency domain. It uses the separable method: one 1D pass over each row, then a second 1D pass over each column of the row results. A single datapath serves both directions. A mode input picks the direction for each tile: the forward cosine transform (pixels to coefficients) or the inverse transform (coefficients to pixels). Samples arrive one per clock in raster order, and results leave one per clock in raster order.

The row pass builds eight running sums as the samples of a row come in. When a row is complete, the pass writes all eight results into a two-bank transpose store. The column pass reads whole columns out of the bank that was most recently completed. It produces one output per clock while the row pass fills the other bank, so tiles can follow one another with no idle cycles. Cosine constants are 14-bit values derived by a function rather than stored as a table. The intermediate store holds 15-bit values with two fraction bits.

Top module: `dct2d_core`

## Requirements
- R1: Forward mode (mode_inv=0 on the first sample of a tile). in_data[7:0] is an unsigned pixel and in_data[10:8] is ignored. Each output is within 2 of round(sum over x,y of C(u,x)·C(v,y)·(p[x][y]−128)), saturated to −1024..1023 and given as 11-bit two's complement. Here C(u,x)=k(u)/2·cos((2x+1)uπ/16), with k(0)=1/√2 and k(u>0)=1.
- R2: Inverse mode (mode_inv=1 on the first sample). in_data is an 11-bit two's-complement coefficient. Each output is within 2 of round(sum over u,v of C(u,x)·C(v,y)·X[u][v])+128.
- R3: In inverse mode every output is clamped to the range 0..255, so out_data[10:8] is always zero.
- R4: Every accepted 64-sample tile yields exactly 64 outputs, in raster order (output index = 8·row + column). No output appears without an accepted tile.
- R5: out_valid is first asserted at the clock edge right after the edge that accepts the 64th sample of a tile, when no earlier tile is still being output.
- R6: Tiles sent with no gaps produce outputs with no gaps: three such tiles give one unbroken run of 192 valid cycles.
- R7: The mode is taken from mode_inv only on the first sample of a tile. Changes of mode_inv later in the tile have no effect, and each tile is output in its own mode.
- R8: A clr pulse discards any partly received tile and any pending or in-flight outputs. out_valid and busy are low in the cycle after clr, and the next 64 samples form a fresh tile.
- R9: While rst_n is low, out_valid and busy are low.
- R10: busy is high from the edge that accepts a tile's first sample until its last output has been presented. It goes low once nothing remains.
- R11: Cycles with in_valid low pause the intake without changing the tile's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous flush of all tiles in progress |
| mode_inv | input | 1 | 0 = forward transform, 1 = inverse; sampled on a tile's first sample |
| in_valid | input | 1 | in_data carries a sample this cycle |
| in_data | input | 11 | Pixel in bits 7:0 (forward) or signed coefficient (inverse) |
| out_valid | output | 1 | out_data carries a result this cycle |
| out_data | output | 11 | Signed coefficient (forward) or pixel in bits 7:0 (inverse) |
| busy | output | 1 | A tile is being received, stored or output |

## Verification
The bench computes every expected value from the real-valued cosine sums, with a tolerance of 2. A swapped coefficient index, a wrong level shift or a transposed readout therefore shows up as a large error on ramps and random tiles, not as a rounding slip. Inverse tiles with extreme DC and mixed large AC terms drive pixels beyond both ends of the range: a missing clamp would wrap to values near 256 or negative values. Back-to-back tiles with alternating modes catch a bank-swap error or a stall, which would show as a broken valid run or one tile decoded in another tile's mode. Flipping mode_inv in the middle of a tile catches a design that reads the mode on every sample. A clr pulse part-way through intake and another during output expose a design that keeps stale row sums or keeps emitting old results.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int N      = 8;            // tile edge
  localparam int NSAMP  = N * N;        // samples per tile
  localparam int IDX_W  = $clog2(NSAMP);
  localparam int POS_W  = $clog2(N);
  localparam int PIX_W  = 8;            // unsigned pixel width
  localparam int IO_W   = 11;           // signed coefficient width
  localparam int CW     = 14;           // cosine constant width
  localparam int CFRAC  = 13;           // cosine fraction bits
  localparam int TW     = 15;           // transpose store width
  localparam int TFRAC  = 2;            // transpose store fraction bits
  localparam int ACC_W  = 32;           // row accumulator width
  localparam int SUM_W  = 36;           // column sum width
  localparam int LVL    = 1 << (PIX_W - 1);

  // Scaled basis value C(u,x) = k(u)/2 * cos((2x+1)u*pi/16), Q13
  function automatic logic signed [CW-1:0] cos_q(input logic [POS_W-1:0] u,
                                                 input logic [POS_W-1:0] x);
    int m;
    int k;
    int mag;
    logic neg;
    if (u == '0) return CW'(2896);
    m = ((2 * int'(x) + 1) * int'(u)) % 32;
    if (m > 16) m = 32 - m;
    neg = (m > 8);
    k = neg ? 16 - m : m;
    case (k)
      0:       mag = 4096;
      1:       mag = 4017;
      2:       mag = 3784;
      3:       mag = 3406;
      4:       mag = 2896;
      5:       mag = 2276;
      6:       mag = 1567;
      7:       mag = 799;
      default: mag = 0;
    endcase
    return neg ? CW'(-mag) : CW'(mag);
  endfunction

  // Round half up, then arithmetic shift right
  function automatic longint rnd_shift(input longint v, input int sh);
    return (v + (longint'(1) <<< (sh - 1))) >>> sh;
  endfunction

  function automatic longint clip(input longint v, input longint lo, input longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/dct_row_stage.sv
module dct_row_stage
  import dct_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     in_valid,
  input  logic                     mode_in,
  input  logic [IO_W-1:0]          in_data,
  output logic                     row_we,
  output logic [POS_W-1:0]         row_idx,
  output logic [N-1:0][TW-1:0]     row_vals,
  output logic                     row_mode,
  output logic                     blk_done,
  output logic                     rx_busy
);
  logic [IDX_W-1:0]        in_cnt;
  logic                    blk_mode;
  logic signed [ACC_W-1:0] acc [N];
  logic signed [ACC_W-1:0] nxt [N];
  logic signed [ACC_W-1:0] sx;

  wire                 take     = in_valid && !clr;
  wire                 first    = (in_cnt == '0);
  wire                 eff_mode = first ? mode_in : blk_mode;
  wire [POS_W-1:0]     col      = in_cnt[POS_W-1:0];

  // Input conversion: level-shifted pixel or signed coefficient
  always_comb begin
    if (eff_mode) sx = ACC_W'($signed(in_data));
    else          sx = ACC_W'($signed({1'b0, in_data[PIX_W-1:0]})) - ACC_W'(LVL);
  end

  // Eight multiply-accumulate lanes, one per output position of the row
  always_comb begin
    for (int k = 0; k < N; k++) begin
      logic signed [CW-1:0] c;
      c = eff_mode ? cos_q(col, POS_W'(k)) : cos_q(POS_W'(k), col);
      nxt[k] = ((col == '0) ? '0 : acc[k]) + sx * ACC_W'(c);
      row_vals[k] = TW'(clip(rnd_shift(longint'(nxt[k]), CFRAC - TFRAC),
                             -(longint'(1) <<< (TW - 1)),
                             (longint'(1) <<< (TW - 1)) - 1));
    end
  end

  assign row_we   = take && (col == POS_W'(N - 1));
  assign row_idx  = in_cnt[IDX_W-1:POS_W];
  assign row_mode = eff_mode;
  assign blk_done = take && (in_cnt == IDX_W'(NSAMP - 1));
  assign rx_busy  = !first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt   <= '0;
      blk_mode <= 1'b0;
      for (int k = 0; k < N; k++) acc[k] <= '0;
    end else if (clr) begin
      in_cnt <= '0;
    end else if (take) begin
      in_cnt <= in_cnt + 1'b1;
      if (first) blk_mode <= mode_in;
      for (int k = 0; k < N; k++) acc[k] <= nxt[k];
    end
  end

  // R7: the tile's mode cannot move once its first sample is in
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt != '0) |=> $stable(blk_mode));
endmodule

// File: rtl/dct_tbuf.sv
module dct_tbuf
  import dct_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     row_we,
  input  logic [POS_W-1:0]         row_idx,
  input  logic [N-1:0][TW-1:0]     row_vals,
  input  logic                     row_mode,
  input  logic                     blk_done,
  input  logic [POS_W-1:0]         rd_col,
  input  logic                     rd_done,
  output logic                     full_rd,
  output logic                     rd_mode,
  output logic                     any_full,
  output logic [N-1:0][TW-1:0]     col_vals
);
  logic [TW-1:0] mem [2][N][N];
  logic [1:0]    full, full_n, bmode;
  logic          wr_bank, rd_bank;

  always_ff @(posedge clk) begin
    if (row_we)
      for (int k = 0; k < N; k++) mem[wr_bank][row_idx][k] <= row_vals[k];
  end

  always_comb begin
    full_n = full;
    if (blk_done) full_n[wr_bank] = 1'b1;
    if (rd_done)  full_n[rd_bank] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= '0;
      bmode   <= '0;
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
    end else if (clr) begin
      full    <= '0;
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
    end else begin
      full <= full_n;
      if (blk_done) begin
        bmode[wr_bank] <= row_mode;
        wr_bank        <= ~wr_bank;
      end
      if (rd_done) rd_bank <= ~rd_bank;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) col_vals[i] = mem[rd_bank][i][rd_col];
  end

  assign full_rd  = full[rd_bank];
  assign rd_mode  = bmode[rd_bank];
  assign any_full = |full;

  // R6: the row pass never writes into a bank still waiting to be read
  p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    row_we |-> !full[wr_bank]);
endmodule

// File: rtl/dct_col_stage.sv
module dct_col_stage
  import dct_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     full_rd,
  input  logic                     rd_mode,
  input  logic [N-1:0][TW-1:0]     col_vals,
  output logic [POS_W-1:0]         rd_col,
  output logic                     rd_done,
  output logic                     out_valid,
  output logic [IO_W-1:0]          out_data
);
  logic [IDX_W-1:0]        out_cnt;
  logic                    out_inv;
  logic signed [SUM_W-1:0] sum;
  logic [IO_W-1:0]         res;

  wire             active = full_rd;
  wire [POS_W-1:0] u      = out_cnt[IDX_W-1:POS_W];

  assign rd_col  = out_cnt[POS_W-1:0];
  assign rd_done = active && (out_cnt == IDX_W'(NSAMP - 1));

  // Column dot product against the basis row selected by the output row
  always_comb begin
    longint r;
    sum = '0;
    for (int i = 0; i < N; i++) begin
      logic signed [CW-1:0] c;
      c = rd_mode ? cos_q(POS_W'(i), u) : cos_q(u, POS_W'(i));
      sum = sum + SUM_W'($signed(col_vals[i])) * SUM_W'(c);
    end
    r = rnd_shift(longint'(sum), CFRAC + TFRAC);
    if (rd_mode) res = IO_W'(clip(r + LVL, 0, (longint'(1) <<< PIX_W) - 1));
    else         res = IO_W'(clip(r, -(longint'(1) <<< (IO_W - 1)),
                                  (longint'(1) <<< (IO_W - 1)) - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt   <= '0;
      out_valid <= 1'b0;
      out_inv   <= 1'b0;
      out_data  <= '0;
    end else if (clr) begin
      out_cnt   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= active;
      if (active) begin
        out_cnt  <= out_cnt + 1'b1;
        out_data <= res;
        out_inv  <= rd_mode;
      end
    end
  end

  // R3: inverse results stay inside the pixel range
  p_pixel_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inv) |-> (out_data[IO_W-1:PIX_W] == '0));
  // R6: a started tile is read out without a gap
  p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr && out_cnt != IDX_W'(NSAMP - 1)) |=> active);
endmodule

// File: rtl/dct2d_core.sv
module dct2d_core
  import dct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mode_inv,
  input  logic             in_valid,
  input  logic [IO_W-1:0]  in_data,
  output logic             out_valid,
  output logic [IO_W-1:0]  out_data,
  output logic             busy
);
  logic                 row_we, row_mode, blk_done, rx_busy;
  logic [POS_W-1:0]     row_idx, rd_col;
  logic [N-1:0][TW-1:0] row_vals, col_vals;
  logic                 full_rd, rd_mode, any_full, rd_done;

  dct_row_stage u_row (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .mode_in(mode_inv), .in_data(in_data), .row_we(row_we),
    .row_idx(row_idx), .row_vals(row_vals), .row_mode(row_mode),
    .blk_done(blk_done), .rx_busy(rx_busy));

  dct_tbuf u_tbuf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .row_we(row_we),
    .row_idx(row_idx), .row_vals(row_vals), .row_mode(row_mode),
    .blk_done(blk_done), .rd_col(rd_col), .rd_done(rd_done),
    .full_rd(full_rd), .rd_mode(rd_mode), .any_full(any_full),
    .col_vals(col_vals));

  dct_col_stage u_col (
    .clk(clk), .rst_n(rst_n), .clr(clr), .full_rd(full_rd),
    .rd_mode(rd_mode), .col_vals(col_vals), .rd_col(rd_col),
    .rd_done(rd_done), .out_valid(out_valid), .out_data(out_data));

  assign busy = rx_busy | any_full | out_valid;

  // R8: a flush leaves nothing behind
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_valid && !busy));
  // R9: outputs quiet while in reset
  always_comb begin
    if (!rst_n) p_reset_quiet_r9: assert (!out_valid && !busy);
  end
endmodule

// File: tb/dct2d_core_tb_top.sv
module dct2d_core_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, clr = 1'b0, mode_inv = 1'b0, in_valid = 1'b0;
  logic [10:0] in_data = '0;
  wire         out_valid, busy;
  wire  [10:0] out_data;

  dct2d_core dut_i (.clk(clk), .rst_n(rst_n), .clr(clr), .mode_inv(mode_inv),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .busy(busy));

  always #10 clk = ~clk;   // 50 MHz

  int    checks = 0, errors = 0;
  int    blk [64];
  int    exp_q [$];
  string tag_q [$];
  int    cur_run = 0, last_run = 0;
  int    m_e, m_a;
  string m_t;
  bit    finished = 1'b0;

  function automatic real basis(int u, int x);
    real s = (u == 0) ? 0.5 / $sqrt(2.0) : 0.5;
    return s * $cos(real'((2 * x + 1) * u) * 3.14159265358979 / 16.0);
  endfunction

  function automatic int rnd(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Reference model written as the plain double sums of the requirements
  task automatic push_exp(bit inv, string tag);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        real s = 0.0;
        int  e;
        for (int a = 0; a < 8; a++)
          for (int b = 0; b < 8; b++)
            if (inv) s += basis(a, r) * basis(b, c) * blk[a * 8 + b];
            else     s += basis(r, a) * basis(c, b) * (blk[a * 8 + b] - 128);
        e = rnd(s);
        if (inv) begin e += 128; e = (e < 0) ? 0 : (e > 255) ? 255 : e; end
        else     e = (e < -1024) ? -1024 : (e > 1023) ? 1023 : e;
        exp_q.push_back(e);
        tag_q.push_back(tag);
      end
  endtask

  // Scoreboard and valid-run tracker
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      cur_run++;
      if (exp_q.size() == 0) chk(1'b0, "R4 extra output", int'($signed(out_data)), 0);
      else begin
        m_e = exp_q.pop_front();
        m_t = tag_q.pop_front();
        m_a = int'($signed(out_data));
        chk((m_a - m_e <= 2) && (m_e - m_a <= 2), m_t, m_a, m_e);
      end
    end else if (cur_run > 0) begin
      last_run = cur_run;
      cur_run  = 0;
    end
  end

  task automatic send_sample(bit m, int v);
    @(negedge clk);
    in_valid = 1'b1; mode_inv = m; in_data = 11'(v);
  endtask

  task automatic send_block(bit m);
    for (int i = 0; i < 64; i++) send_sample(m, blk[i]);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 400 && (exp_q.size() != 0 || out_valid); i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!out_valid, "R9 out_valid in reset", int'(out_valid), 0);
    chk(!busy, "R9 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid, "R9 after reset", int'(busy), 0);
  endtask

  task automatic t_forward();
    for (int i = 0; i < 64; i++) blk[i] = 128;
    push_exp(0, "R1 flat mid"); send_block(0); idle(); drain("R1 flat mid");
    for (int i = 0; i < 64; i++) blk[i] = 255;
    push_exp(0, "R1 flat max"); send_block(0); idle(); drain("R1 flat max");
    for (int i = 0; i < 64; i++) blk[i] = i * 4;
    push_exp(0, "R4 ramp order"); send_block(0); idle(); drain("R4 ramp order");
    for (int i = 0; i < 64; i++) blk[i] = ((i / 8 + i % 8) % 2) ? 0 : 255;
    push_exp(0, "R1 checker"); send_block(0); idle(); drain("R1 checker");
    for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 255);
    push_exp(0, "R1 random"); send_block(0); idle(); drain("R1 random");
  endtask

  task automatic t_inverse();
    for (int i = 0; i < 64; i++) blk[i] = 0;
    blk[0] = 400;
    push_exp(1, "R2 dc only"); send_block(1); idle(); drain("R2 dc only");
    for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 200) - 100;
    push_exp(1, "R2 random"); send_block(1); idle(); drain("R2 random");
    for (int i = 0; i < 64; i++) blk[i] = 0;
    blk[0] = 1023;
    push_exp(1, "R3 clamp high"); send_block(1); idle(); drain("R3 clamp high");
    blk[0] = -1024;
    push_exp(1, "R3 clamp low"); send_block(1); idle(); drain("R3 clamp low");
    blk[0] = 100; blk[1] = -900; blk[8] = 700;
    push_exp(1, "R3 clamp mixed"); send_block(1); idle(); drain("R3 clamp mixed");
  endtask

  task automatic t_latency();
    for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 255);
    push_exp(0, "R5 values");
    send_block(0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid, "R5 not before", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid, "R5 first output", int'(out_valid), 1);
    drain("R5 values");
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 255);
    push_exp(0, "R7 tile A fwd"); send_block(0);
    for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 300) - 150;
    push_exp(1, "R7 tile B inv"); send_block(1);
    for (int i = 0; i < 64; i++) blk[i] = 255 - i * 3;
    push_exp(0, "R7 tile C fwd"); send_block(0);
    idle();
    drain("R6 stream");
    chk(last_run == 192, "R6 unbroken run", last_run, 192);
  endtask

  task automatic t_mode_mid();
    for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 255);
    push_exp(0, "R7 mid flip to inv");
    for (int i = 0; i < 64; i++) send_sample(i != 0, blk[i]);
    idle(); drain("R7 mid flip to inv");
    for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 120) - 60;
    push_exp(1, "R7 mid flip to fwd");
    for (int i = 0; i < 64; i++) send_sample(i == 0, blk[i]);
    idle(); drain("R7 mid flip to fwd");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 255);
    push_exp(0, "R11 gapped intake");
    for (int i = 0; i < 64; i++) begin
      send_sample(0, blk[i]);
      if (i % 5 == 4) begin idle(); idle(); end
    end
    idle(); drain("R11 gapped intake");
  endtask

  task automatic t_clear();
    for (int i = 0; i < 30; i++) send_sample(0, 77);
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(!busy, "R8 busy after flush", int'(busy), 0);
    for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 255);
    push_exp(0, "R8 fresh tile"); send_block(0); idle(); drain("R8 fresh tile");
    push_exp(0, "R8 output flush");
    send_block(0); idle();
    while (!out_valid) @(negedge clk);
    repeat (5) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(!out_valid, "R8 out_valid after clr", int'(out_valid), 0);
    chk(!busy, "R8 busy after clr", int'(busy), 0);
    exp_q.delete(); tag_q.delete();
    repeat (70) @(negedge clk);
    chk(!out_valid, "R8 stays silent", int'(out_valid), 0);
  endtask

  task automatic t_busy();
    int bad = 0;
    chk(!busy, "R10 idle", int'(busy), 0);
    for (int i = 0; i < 64; i++) blk[i] = $urandom_range(0, 255);
    push_exp(0, "R10 values");
    for (int i = 0; i < 64; i++) begin
      send_sample(0, blk[i]);
      if (i == 1) chk(busy, "R10 busy after first sample", int'(busy), 1);
    end
    idle();
    while (!out_valid) @(negedge clk);
    while (out_valid) begin
      if (!busy) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R10 busy during output", bad, 0);
    chk(!busy, "R10 busy drops", int'(busy), 0);
    drain("R10 values");
  endtask

  initial begin
    t_reset();
    t_forward();
    t_inverse();
    t_latency();
    t_back_to_back();
    t_mode_mid();
    t_gaps();
    t_clear();
    t_busy();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule